// File: doc/BRIEF.md
# Level-Masked Interrupt Acceptance Controller

This block sits between a set of on-chip peripheral interrupt sources and the CPU's interrupt microsequence. Every source offers an enable bit, a request bit and a three-bit priority level. The block qualifies each source, picks one winner among those pending in the same cycle, and decides whether the CPU may take it. That decision uses a global interrupt-enable flag and a running interrupt level mask (ILM) that the block itself holds.

When a request is accepted, the block drives a fixed run of one-hot register-save strobes that a stack-push datapath consumes. It then writes the accepted level into the mask, so that only strictly more urgent requests can nest on top. It presents the interrupt number and the vector fetch address taken from a vector table at the top of memory. A single-cycle done pulse ends the sequence, and the block then returns to idle.

The CPU can load the mask through a dedicated load port, for example when it restores the status word on return from a handler.

Top module: `irqc_accept_ctrl`

## Requirements
- R1: A source is pending only when its enable bit and its request bit are both 1 and its level is not 7. Level 7 means the source is switched off.
- R2: Among pending sources, the one with the numerically smallest level wins. When levels are equal, the lowest source index wins.
- R3: The winner is accepted only while `i_flag` is 1 and its level is strictly less than the current ILM. A request whose level equals the ILM is blocked.
- R4: After acceptance, `save_strobe` is one-hot for seven consecutive cycles, starting in the cycle after the accepting edge. The bits go in the order bit0 = accumulator, bit1 = direct page, bit2 = additional data bank, bit3 = data bank, bit4 = program bank, bit5 = program counter, bit6 = status word. Outside these seven cycles `save_strobe` is 0.
- R5: In the cycle after the last strobe, `done` is 1 for exactly one cycle and `ilm` already equals the accepted level.
- R6: From the first strobe cycle through the done cycle, `ack_num` equals IRQ_BASE plus the source index. Over the same cycles, `vec_addr` equals 0xFFFFFC minus four times `ack_num` (IRQ_BASE defaults to 11).
- R7: While `busy` is 1, changes on the request, level, enable, flag and mask-load inputs have no effect. The strobe run, `ack_num`, `vec_addr` and `ilm` behave as if those inputs had not changed.
- R8: In idle, a pulse on `ilm_set` loads `ilm_set_val` into the ILM at the next edge. In that same cycle it takes precedence over acceptance, so no request is accepted at that edge.
- R9: After reset the block is idle: `busy`, `done` and `save_strobe` are 0 and `ilm` is 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_en | input | NUM_SRC | Per-source interrupt enable |
| src_req | input | NUM_SRC | Per-source interrupt request |
| src_lvl | input | NUM_SRC*LVL_W | Per-source priority level, source i at bits [i*LVL_W +: LVL_W] |
| i_flag | input | 1 | Global interrupt enable from the status word |
| ilm_set | input | 1 | Load pulse for the interrupt level mask |
| ilm_set_val | input | LVL_W | Value loaded by `ilm_set` |
| save_strobe | output | 7 | One-hot register-save strobe |
| busy | output | 1 | Acceptance sequence in progress |
| done | output | 1 | Single-cycle end-of-sequence pulse |
| ilm | output | LVL_W | Current interrupt level mask |
| ack_num | output | NUM_W | Accepted interrupt number |
| vec_addr | output | ADDR_W | Vector fetch address of the accepted interrupt |

## Verification
Suppose the winner latch or the arbitration is corrupt. The wrong source then shows up in `ack_num` and `vec_addr` in the very first strobe cycle, one cycle after the accepting edge. A wrong step counter shows up the same way, as a strobe that skips a bit, repeats a bit or runs one cycle too long. A mask that is loaded wrongly or not at all is visible on `ilm` in the done cycle, eight cycles after acceptance. It then shows again in the next decision, where a request at or below the old level is either taken or blocked when it should not be. An acceptance that ignores `i_flag` or uses a non-strict comparison raises `busy` one cycle after a stimulus that should have left it low.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Number of registers pushed to the stack on acceptance
    localparam int SAVE_STEPS = 7;

    // Strobe bit positions, in push order
    typedef enum logic [2:0] {
        SV_ACC   = 3'd0,
        SV_DPAGE = 3'd1,
        SV_ADBNK = 3'd2,
        SV_DBNK  = 3'd3,
        SV_PBNK  = 3'd4,
        SV_PCNT  = 3'd5,
        SV_STAT  = 3'd6
    } save_slot_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SAVE = 2'd1,
        ST_DONE = 2'd2
    } acc_state_e;

endpackage

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
    parameter int NUM_SRC = 8,
    parameter int LVL_W   = 3,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       src_en,
    input  logic [NUM_SRC-1:0]       src_req,
    input  logic [NUM_SRC*LVL_W-1:0] src_lvl,
    output logic                     win_valid,
    output logic [IDX_W-1:0]         win_idx,
    output logic [LVL_W-1:0]         win_lvl
);

    localparam logic [LVL_W-1:0] LVL_OFF = '1;

    logic [NUM_SRC-1:0] pend;
    logic [LVL_W-1:0]   lvl_a [NUM_SRC];

    // Qualify every source
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_qual
        assign lvl_a[g] = src_lvl[g*LVL_W +: LVL_W];
        assign pend[g]  = src_en[g] & src_req[g] & (lvl_a[g] != LVL_OFF);
    end

    // Ascending scan with strict compare: ties keep the lower index
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_lvl   = LVL_OFF;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pend[i] && (!win_valid || (lvl_a[i] < win_lvl))) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                win_lvl   = lvl_a[i];
            end
        end
    end

    // R1: the winner is a qualified source
    p_win_pending_r1: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (src_en[win_idx] && src_req[win_idx] && (win_lvl != LVL_OFF)));

    // R1: any pending source means a winner exists
    p_win_exists_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pend != '0) |-> win_valid);

    // R2: no pending source is more urgent than the winner, ties go low
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
        p_win_min_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (win_valid && pend[g]) |->
                ((lvl_a[g] > win_lvl) || ((lvl_a[g] == win_lvl) && (IDX_W'(g) >= win_idx))));
    end

endmodule

// File: rtl/irqc_vecgen.sv
module irqc_vecgen #(
    parameter int NUM_SRC  = 8,
    parameter int IRQ_BASE = 11,
    parameter int NUM_W    = 8,
    parameter int ADDR_W   = 24,
    localparam int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [NUM_W-1:0]  num,
    output logic [ADDR_W-1:0] vec
);

    // Last 4-byte entry of the address space
    localparam logic [ADDR_W-1:0] VEC_TOP = {{(ADDR_W-2){1'b1}}, 2'b00};

    logic [ADDR_W-1:0] offs;

    always_comb begin
        num  = NUM_W'(IRQ_BASE) + NUM_W'(idx);
        offs = ADDR_W'(num) << 2;
        vec  = VEC_TOP - offs;
    end

endmodule

// File: rtl/irqc_seq.sv
module irqc_seq
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int LVL_W   = 3,
    parameter int NUM_W   = 8,
    parameter int ADDR_W  = 24,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  i_flag,
    input  logic                  ilm_set,
    input  logic [LVL_W-1:0]      ilm_set_val,
    input  logic                  win_valid,
    input  logic [LVL_W-1:0]      win_lvl,
    input  logic [NUM_W-1:0]      win_num,
    input  logic [ADDR_W-1:0]     win_vec,
    output logic [SAVE_STEPS-1:0] save_strobe,
    output logic                  busy,
    output logic                  done,
    output logic [LVL_W-1:0]      ilm,
    output logic [NUM_W-1:0]      ack_num,
    output logic [ADDR_W-1:0]     vec_addr
);

    localparam logic [2:0] LAST_STEP = 3'(SAVE_STEPS - 1);

    typedef struct packed {
        acc_state_e        state;
        logic [2:0]        step;
        logic [LVL_W-1:0]  ilm;
        logic [LVL_W-1:0]  lvl;
        logic [NUM_W-1:0]  num;
        logic [ADDR_W-1:0] vec;
    } seq_t;

    seq_t r_d, r_q;
    logic take;

    always_comb begin
        r_d  = r_q;
        take = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (ilm_set) begin
                    r_d.ilm = ilm_set_val;
                end else if (win_valid && i_flag && (win_lvl < r_q.ilm)) begin
                    take      = 1'b1;
                    r_d.state = ST_SAVE;
                    r_d.step  = '0;
                    r_d.lvl   = win_lvl;
                    r_d.num   = win_num;
                    r_d.vec   = win_vec;
                end
            end
            ST_SAVE: begin
                if (r_q.step == LAST_STEP) begin
                    r_d.state = ST_DONE;
                    r_d.ilm   = r_q.lvl;
                end else begin
                    r_d.step = r_q.step + 3'd1;
                end
            end
            ST_DONE: begin
                r_d.state = ST_IDLE;
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.step  <= '0;
            r_q.ilm   <= '1;
            r_q.lvl   <= '1;
            r_q.num   <= '0;
            r_q.vec   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        save_strobe = '0;
        if (r_q.state == ST_SAVE) begin
            save_strobe[r_q.step] = 1'b1;
        end
    end

    assign busy     = (r_q.state != ST_IDLE);
    assign done     = (r_q.state == ST_DONE);
    assign ilm      = r_q.ilm;
    assign ack_num  = r_q.num;
    assign vec_addr = r_q.vec;

    // R3: the sequence only starts from an allowed request
    p_accept_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(i_flag) && $past(win_valid) && ($past(win_lvl) < $past(ilm))));

    // R4: at most one strobe active
    p_strobe_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(save_strobe));

    // R4: strobes advance one slot per cycle
    p_strobe_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((save_strobe != '0) && !save_strobe[SV_STAT]) |=> (save_strobe == ($past(save_strobe) << 1)));

    // R4: the run starts at the first slot
    p_strobe_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> save_strobe[SV_ACC]);

    // R5: last strobe is followed by done with the mask loaded
    p_done_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        save_strobe[SV_STAT] |=> (done && (ilm < $past(ilm))));

    // R5: done is a single pulse
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: mask and vector hold while strobing
    p_hold_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (save_strobe != '0) && !$rose(busy) |-> ($stable(ilm) && $stable(vec_addr) && $stable(ack_num)));

    // R8: an idle mask load lands on the next edge and blocks acceptance
    p_ilm_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ilm_set && !busy) |=> ((ilm == $past(ilm_set_val)) && !busy));

endmodule

// File: rtl/irqc_accept_ctrl.sv
module irqc_accept_ctrl #(
    parameter int NUM_SRC  = 8,
    parameter int LVL_W    = 3,
    parameter int IRQ_BASE = 11,
    parameter int NUM_W    = 8,
    parameter int ADDR_W   = 24,
    localparam int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int SAVE_N  = irqc_pkg::SAVE_STEPS
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       src_en,
    input  logic [NUM_SRC-1:0]       src_req,
    input  logic [NUM_SRC*LVL_W-1:0] src_lvl,
    input  logic                     i_flag,
    input  logic                     ilm_set,
    input  logic [LVL_W-1:0]         ilm_set_val,
    output logic [SAVE_N-1:0]        save_strobe,
    output logic                     busy,
    output logic                     done,
    output logic [LVL_W-1:0]         ilm,
    output logic [NUM_W-1:0]         ack_num,
    output logic [ADDR_W-1:0]        vec_addr
);

    logic              win_valid;
    logic [IDX_W-1:0]  win_idx;
    logic [LVL_W-1:0]  win_lvl;
    logic [NUM_W-1:0]  win_num;
    logic [ADDR_W-1:0] win_vec;

    irqc_arbiter #(
        .NUM_SRC (NUM_SRC),
        .LVL_W   (LVL_W)
    ) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_en    (src_en),
        .src_req   (src_req),
        .src_lvl   (src_lvl),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_lvl   (win_lvl)
    );

    irqc_vecgen #(
        .NUM_SRC  (NUM_SRC),
        .IRQ_BASE (IRQ_BASE),
        .NUM_W    (NUM_W),
        .ADDR_W   (ADDR_W)
    ) u_vec (
        .idx (win_idx),
        .num (win_num),
        .vec (win_vec)
    );

    irqc_seq #(
        .NUM_SRC (NUM_SRC),
        .LVL_W   (LVL_W),
        .NUM_W   (NUM_W),
        .ADDR_W  (ADDR_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .i_flag      (i_flag),
        .ilm_set     (ilm_set),
        .ilm_set_val (ilm_set_val),
        .win_valid   (win_valid),
        .win_lvl     (win_lvl),
        .win_num     (win_num),
        .win_vec     (win_vec),
        .save_strobe (save_strobe),
        .busy        (busy),
        .done        (done),
        .ilm         (ilm),
        .ack_num     (ack_num),
        .vec_addr    (vec_addr)
    );

endmodule

// File: tb/irqc_accept_ctrl_bench.sv
module irqc_accept_ctrl_bench;

    localparam int N    = 8;
    localparam int LW   = 3;
    localparam int BASE = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src_en = '0;
    logic [N-1:0]  src_req = '0;
    logic [N*LW-1:0] src_lvl = '1;
    logic          i_flag = 1'b0;
    logic          ilm_set = 1'b0;
    logic [LW-1:0] ilm_set_val = '0;
    logic [6:0]    save_strobe;
    logic          busy, done;
    logic [LW-1:0] ilm;
    logic [7:0]    ack_num;
    logic [23:0]   vec_addr;

    int n_run = 0;
    int n_fail = 0;
    int ilm_m = 7;

    always #10 clk = ~clk;

    irqc_accept_ctrl u_irqc_accept_ctrl (
        .clk(clk), .rst_n(rst_n), .src_en(src_en), .src_req(src_req),
        .src_lvl(src_lvl), .i_flag(i_flag), .ilm_set(ilm_set),
        .ilm_set_val(ilm_set_val), .save_strobe(save_strobe), .busy(busy),
        .done(done), .ilm(ilm), .ack_num(ack_num), .vec_addr(vec_addr)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected winner index per R1/R2, -1 if none
    function automatic int exp_pick(input logic [N-1:0] en, input logic [N-1:0] rq,
                                    input logic [N*LW-1:0] lv);
        int best = -1;
        int bl = 8;
        for (int i = 0; i < N; i++) begin
            int l = int'(lv[i*LW +: LW]);
            if (en[i] && rq[i] && l != 7 && l < bl) begin
                best = i;
                bl = l;
            end
        end
        return best;
    endfunction

    function automatic logic [23:0] exp_vec(input int idx);
        return 24'hFFFFFC - 24'(4 * (BASE + idx));
    endfunction

    task automatic set_ilm(input int v);
        @(negedge clk);
        ilm_set = 1'b1;
        ilm_set_val = LW'(v);
        @(negedge clk);
        ilm_set = 1'b0;
        ilm_m = v;
        chk(ilm == LW'(v), "R8", ilm, v);
    endtask

    // Drive one stimulus and check accept/block and the whole sequence
    task automatic run(input logic [N-1:0] en, input logic [N-1:0] rq,
                       input logic [N*LW-1:0] lv, input logic fl);
        int w = exp_pick(en, rq, lv);
        int wl = (w >= 0) ? int'(lv[w*LW +: LW]) : 7;
        bit acc = (w >= 0) && fl && (wl < ilm_m);
        @(negedge clk);
        src_en = en; src_req = rq; src_lvl = lv; i_flag = fl;
        @(negedge clk);
        if (!acc) begin
            chk(!busy && save_strobe == 0, "R3", busy, 0);
        end else begin
            for (int k = 0; k < 7; k++) begin
                chk(save_strobe == 7'(1 << k), "R4", save_strobe, 1 << k);
                chk(ilm == LW'(ilm_m), "R7", ilm, ilm_m);
                if (k == 0) begin
                    chk(ack_num == 8'(BASE + w), "R2", ack_num, BASE + w);
                    chk(vec_addr == exp_vec(w), "R6", vec_addr, exp_vec(w));
                    // R7: scramble inputs while busy
                    src_en = N'($urandom); src_req = N'($urandom);
                    src_lvl = (N*LW)'($urandom); i_flag = 1'($urandom);
                    ilm_set = 1'b1; ilm_set_val = LW'($urandom);
                end
                @(negedge clk);
            end
            ilm_set = 1'b0;
            chk(done && save_strobe == 0, "R5", {done, save_strobe}, 8'h80);
            chk(ilm == LW'(wl), "R5", ilm, wl);
            chk(vec_addr == exp_vec(w) && ack_num == 8'(BASE + w), "R6", vec_addr, exp_vec(w));
            ilm_m = wl;
            src_req = '0;
            @(negedge clk);
            chk(!done && !busy, "R5", {busy, done}, 0);
        end
        src_req = '0;
    endtask

    function automatic logic [N*LW-1:0] one_lvl(input int idx, input int l);
        logic [N*LW-1:0] v = '1;
        v[idx*LW +: LW] = LW'(l);
        return v;
    endfunction

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(!busy && !done && save_strobe == 0, "R9", {busy, done, save_strobe}, 0);
        chk(ilm == 3'd7, "R9", ilm, 7);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && ilm == 3'd7, "R9", ilm, 7);

        // R1: enable without request, request without enable, level 7
        run(8'h01, 8'h00, one_lvl(0, 1), 1'b1);
        run(8'h00, 8'h01, one_lvl(0, 1), 1'b1);
        run(8'h01, 8'h01, one_lvl(0, 7), 1'b1);

        // R2: tie on level, lower index wins
        begin
            logic [N*LW-1:0] v = '1;
            v[5*LW +: LW] = 3'd3; v[2*LW +: LW] = 3'd3; v[6*LW +: LW] = 3'd5;
            run(8'hFF, 8'h64, v, 1'b1);
        end
        set_ilm(7);

        // R3 nesting: accept 4, block 4, accept 2, block all with flag low
        run(8'h08, 8'h08, one_lvl(3, 4), 1'b1);
        chk(ilm_m == 4, "R3", ilm_m, 4);
        run(8'h10, 8'h10, one_lvl(4, 4), 1'b1);
        run(8'h10, 8'h10, one_lvl(4, 2), 1'b1);
        chk(ilm_m == 2, "R3", ilm_m, 2);
        run(8'h01, 8'h01, one_lvl(0, 0), 1'b0);
        set_ilm(7);

        // R8: mask load beats a pending request in the same cycle
        @(negedge clk);
        src_en = 8'h02; src_req = 8'h02; src_lvl = one_lvl(1, 1); i_flag = 1'b1;
        ilm_set = 1'b1; ilm_set_val = 3'd1;
        @(negedge clk);
        ilm_set = 1'b0; ilm_m = 1;
        chk(!busy && ilm == 3'd1, "R8", {busy, ilm}, 1);
        @(negedge clk);
        chk(!busy, "R3", busy, 0);
        src_req = '0;
        set_ilm(7);

        // Constrained random mix
        for (int it = 0; it < 60; it++) begin
            if (($urandom % 4) == 0) set_ilm(int'($urandom % 8));
            run(N'($urandom), N'($urandom), (N*LW)'($urandom), (($urandom % 5) != 0));
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule